// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block accepts an interrupt command from the local processor as two 32-bit writes. The high word carries the destination byte and is stored only. A write to the low word starts a dispatch. In that same cycle the block decodes four things from the low word: the destination shorthand, the destination mode, the delivery mode and the vector. It turns them into a mask with one bit per processor, for up to `NUM_CPU` processors.

One cycle after the low-word write, the block registers the mask, the delivery-mode code and the vector. Two actions are gated per processor by the mask:

- An INIT command fires a reset pulse to each targeted processor.
- A startup command fires a start pulse to each targeted processor that was halted when the command arrived. It also publishes the real-mode code-segment selector and base derived from the vector.

Logical destinations are matched with a flat bitmap AND, not clusters. Lowest-priority delivery does no arbitration: it simply targets the sender.

Top module: `ipi_dispatch`

## Requirements
- R1: A high-word write (`hi_wr` with `lo_wr` low) only stores `wdata[31:24]` as the destination byte. On the following cycle `dispatch_valid` stays low and `target_mask` keeps its value.
- R2: Shorthand (`wdata[19:18]` of the low word) code 0 with destination mode (`wdata[11]`) 0 is physical:
  - a destination byte of 0xFF sets every mask bit;
  - any other value sets only the bit whose index equals the byte;
  - a byte of `NUM_CPU` or above sets no bit.
- R3: Shorthand 0 with mode 1 is logical: mask bit i is set exactly when the destination byte ANDed with processor i's 8-bit logical ID (`logical_ids[8i+7:8i]`) is nonzero.
- R4: Shorthand 1 sets only the bit of `self_id`. The mask is empty when `self_id` is `NUM_CPU` or above.
- R5: Shorthand 2 sets every mask bit.
- R6: Shorthand 3 sets every mask bit except the bit of `self_id`.
- R7: With delivery mode (`wdata[10:8]`) 1, lowest priority, and shorthand 0, `self_id` replaces the stored destination byte. The destination mode still applies.
- R8: Delivery mode 5 (INIT) raises `init_pulse` equal to the mask for exactly the one cycle after the low-word write.
- R9: Delivery mode 6 (startup) raises `start_pulse` equal to the mask ANDed with `halted`, with `halted` sampled in the strobe cycle, for exactly one cycle. Targets that are not halted get no pulse.
- R10: On a startup dispatch, `start_sel` becomes vector (`wdata[7:0]`) shifted left 8 and `start_base` becomes vector shifted left 12. The instruction pointer is 0 and the limit is 0xFFFF; neither is output. Both values hold until the next startup dispatch.
- R11: One cycle after a low-word write, `target_mask`, `dlv_mode` and `vector` show the decoded command and `dispatch_valid` pulses for one cycle. All three values hold until the next low-word write.
- R12: Delivery modes other than 5 and 6 produce no `init_pulse` and no `start_pulse`.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_wr | input | 1 | Store destination byte from `wdata` |
| lo_wr | input | 1 | Low command word write; dispatch strobe |
| wdata | input | 32 | Command word data |
| self_id | input | 8 | ID of the sending processor |
| logical_ids | input | NUM_CPU*8 | Logical ID of each processor, 8 bits each |
| halted | input | NUM_CPU | Per-processor halted state |
| target_mask | output | NUM_CPU | Registered target mask |
| dlv_mode | output | 3 | Registered delivery-mode code |
| vector | output | 8 | Registered vector |
| dispatch_valid | output | 1 | One-cycle pulse per dispatch |
| init_pulse | output | NUM_CPU | Per-processor INIT pulse |
| start_pulse | output | NUM_CPU | Per-processor startup pulse |
| start_sel | output | 16 | Code-segment selector for started processors |
| start_base | output | 20 | Code-segment base for started processors |

## Verification
A wrong internal state shows at the ports one cycle after the strobe, because every output is a single register stage.

- A shorthand or destination-mode decode error appears as a wrong `target_mask` on that same cycle.
- A stale destination byte yields a mask for the previous destination.
- A missed `halted` gate shows up as a `start_pulse` bit on a running processor.
- A stuck pulse register shows as a pulse still high on the second cycle after the strobe.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_W = 8;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_START  = 3'd6;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    shorthand_e shorthand;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vec;
  } lo_cmd_t;

  function automatic lo_cmd_t decode_lo(input logic [31:0] w);
    lo_cmd_t c;
    c.shorthand = shorthand_e'(w[19:18]);
    c.logical   = w[11];
    c.mode      = w[10:8];
    c.vec       = w[7:0];
    return c;
  endfunction

  function automatic logic [ID_W-1:0] decode_hi(input logic [31:0] w);
    return w[31:24];
  endfunction

  function automatic logic [15:0] start_selector(input logic [7:0] v);
    return {v, 8'h00};
  endfunction

  function automatic logic [19:0] start_segbase(input logic [7:0] v);
    return {v, 12'h000};
  endfunction
endpackage

// File: rtl/ipi_target_mask.sv
module ipi_target_mask
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 32
) (
  input  shorthand_e                 shorthand,
  input  logic                       logical,
  input  logic [ID_W-1:0]            dest,
  input  logic [ID_W-1:0]            self_id,
  input  logic [NUM_CPU*ID_W-1:0]    logical_ids,
  output logic [NUM_CPU-1:0]         mask
);
  logic [NUM_CPU-1:0] phys_hit, log_hit, self_hit;
  logic               dest_bcast;

  assign dest_bcast = (dest == {ID_W{1'b1}});

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    assign phys_hit[i] = dest_bcast || (dest == ID_W'(i));
    assign log_hit[i]  = |(dest & logical_ids[i*ID_W +: ID_W]);
    assign self_hit[i] = (self_id == ID_W'(i));
  end

  always_comb begin
    unique case (shorthand)
      SH_FIELD:  mask = logical ? log_hit : phys_hit;
      SH_SELF:   mask = self_hit;
      SH_ALL:    mask = {NUM_CPU{1'b1}};
      SH_OTHERS: mask = ~self_hit;
      default:   mask = '0;
    endcase
  end
endmodule

// File: rtl/ipi_action.sv
module ipi_action
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [2:0]         mode,
  input  logic [7:0]         vec,
  input  logic [NUM_CPU-1:0] mask,
  input  logic [NUM_CPU-1:0] halted,
  output logic [NUM_CPU-1:0] init_pulse,
  output logic [NUM_CPU-1:0] start_pulse,
  output logic [15:0]        start_sel,
  output logic [19:0]        start_base
);
  logic is_init, is_start;
  assign is_init  = fire && (mode == DM_INIT);
  assign is_start = fire && (mode == DM_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_pulse  <= '0;
      start_pulse <= '0;
      start_sel   <= '0;
      start_base  <= '0;
    end else begin
      init_pulse  <= is_init  ? mask : '0;
      start_pulse <= is_start ? (mask & halted) : '0;
      if (is_start) begin
        start_sel  <= start_selector(vec);
        start_base <= start_segbase(vec);
      end
    end
  end

  assert_init_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> (init_pulse == '0) && (start_pulse == '0));
  assert_start_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((start_pulse & ~$past(halted)) == '0));
  assert_other_modes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (mode != DM_INIT) && (mode != DM_START) |=>
      (init_pulse == '0) && (start_pulse == '0));
  assert_sel_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse != '0) |-> (start_base == {start_sel, 4'h0}));
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hi_wr,
  input  logic                    lo_wr,
  input  logic [31:0]             wdata,
  input  logic [7:0]              self_id,
  input  logic [NUM_CPU*8-1:0]    logical_ids,
  input  logic [NUM_CPU-1:0]      halted,
  output logic [NUM_CPU-1:0]      target_mask,
  output logic [2:0]              dlv_mode,
  output logic [7:0]              vector,
  output logic                    dispatch_valid,
  output logic [NUM_CPU-1:0]      init_pulse,
  output logic [NUM_CPU-1:0]      start_pulse,
  output logic [15:0]             start_sel,
  output logic [19:0]             start_base
);
  logic [ID_W-1:0]    dest_q;
  lo_cmd_t            cmd;
  logic [ID_W-1:0]    dest_eff;
  logic [NUM_CPU-1:0] mask_next;

  assign cmd      = decode_lo(wdata);
  assign dest_eff = (cmd.mode == DM_LOWEST) ? self_id : dest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dest_q <= '0;
    else if (hi_wr) dest_q <= decode_hi(wdata);
  end

  ipi_target_mask #(.NUM_CPU(NUM_CPU)) u_mask (
    .shorthand   (cmd.shorthand),
    .logical     (cmd.logical),
    .dest        (dest_eff),
    .self_id     (self_id),
    .logical_ids (logical_ids),
    .mask        (mask_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_mask    <= '0;
      dlv_mode       <= '0;
      vector         <= '0;
      dispatch_valid <= 1'b0;
    end else begin
      dispatch_valid <= lo_wr;
      if (lo_wr) begin
        target_mask <= mask_next;
        dlv_mode    <= cmd.mode;
        vector      <= cmd.vec;
      end
    end
  end

  ipi_action #(.NUM_CPU(NUM_CPU)) u_action (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (lo_wr),
    .mode        (cmd.mode),
    .vec         (cmd.vec),
    .mask        (mask_next),
    .halted      (halted),
    .init_pulse  (init_pulse),
    .start_pulse (start_pulse),
    .start_sel   (start_sel),
    .start_base  (start_base)
  );

  assert_hi_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr && !lo_wr |=> !dispatch_valid && $stable(target_mask));
  assert_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && (cmd.shorthand == SH_ALL) |=> (target_mask == {NUM_CPU{1'b1}}));
  assert_others_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr && (cmd.shorthand == SH_OTHERS) |=>
      (((NUM_CPU'(1) << $past(self_id)) & target_mask) == '0));
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_valid |-> $past(lo_wr));
  assert_init_in_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pulse & ~target_mask) == '0);
endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hi_wr = 1'b0, lo_wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [7:0]    self_id = '0;
  logic [N*8-1:0] logical_ids;
  logic [N-1:0]  halted = '0;
  logic [N-1:0]  target_mask, init_pulse, start_pulse;
  logic [2:0]    dlv_mode;
  logic [7:0]    vector;
  logic          dispatch_valid;
  logic [15:0]   start_sel;
  logic [19:0]   start_base;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_dispatch #(.NUM_CPU(N)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr), .wdata(wdata),
    .self_id(self_id), .logical_ids(logical_ids), .halted(halted),
    .target_mask(target_mask), .dlv_mode(dlv_mode), .vector(vector),
    .dispatch_valid(dispatch_valid), .init_pulse(init_pulse),
    .start_pulse(start_pulse), .start_sel(start_sel), .start_base(start_base));

  function automatic logic [7:0] lid(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  initial for (int i = 0; i < N; i++) logical_ids[i*8 +: 8] = lid(i);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_mask(input int sh, input int lg,
      input logic [7:0] dest, input logic [7:0] self, input int mode);
    logic [N-1:0] m = '0;
    logic [7:0] d = (mode == 1 && sh == 0) ? self : dest;
    for (int i = 0; i < N; i++) begin
      case (sh)
        0: if (lg != 0) m[i] = (d & lid(i)) != 0;
           else m[i] = (d == 8'hFF) || (int'(d) == i);
        1: m[i] = (int'(self) == i);
        2: m[i] = 1'b1;
        default: m[i] = (int'(self) != i);
      endcase
    end
    return m;
  endfunction

  task automatic dispatch(input int sh, input int lg, input logic [7:0] dest,
                          input int mode, input logic [7:0] vec);
    logic [N-1:0] prev, exp_m;
    string req;
    req = (sh == 0) ? ((mode == 1) ? "R7" : (lg != 0 ? "R3" : "R2")) :
          (sh == 1) ? "R4" : (sh == 2) ? "R5" : "R6";
    exp_m = model_mask(sh, lg, dest, self_id, mode);
    @(negedge clk);
    prev = target_mask;
    hi_wr = 1'b1; wdata = {dest, 24'h5A5A5A};
    @(negedge clk);
    hi_wr = 1'b0;
    chk(!dispatch_valid && target_mask == prev, "R1", "hi write only latches",
        64'(target_mask), 64'(prev));
    lo_wr = 1'b1;
    wdata = 32'hFFF00000 | (32'(sh) << 18) | (32'(lg) << 11) | (32'(mode) << 8)
            | 32'(vec) | 32'h0000_F000 & 32'h0;
    @(negedge clk);
    lo_wr = 1'b0; wdata = '0;
    chk(target_mask == exp_m, req, "target mask", 64'(target_mask), 64'(exp_m));
    chk(dispatch_valid && dlv_mode == 3'(mode) && vector == vec, "R11",
        "valid/mode/vector", {dispatch_valid, dlv_mode, vector},
        {1'b1, 3'(mode), vec});
    if (mode == 5)
      chk(init_pulse == exp_m && start_pulse == '0, "R8", "init pulse",
          64'(init_pulse), 64'(exp_m));
    else if (mode == 6) begin
      chk(start_pulse == (exp_m & halted) && init_pulse == '0, "R9",
          "start pulse", 64'(start_pulse), 64'(exp_m & halted));
      chk(start_sel == 16'(vec) * 16'd256 && start_base == 20'(vec) * 20'd4096,
          "R10", "start sel/base", {start_sel, start_base},
          {16'(vec) * 16'd256, 20'(vec) * 20'd4096});
    end else
      chk(init_pulse == '0 && start_pulse == '0, "R12", "no pulses",
          {init_pulse, start_pulse}, 64'h0);
    @(negedge clk);
    chk(!dispatch_valid && init_pulse == '0 && start_pulse == '0 &&
        target_mask == exp_m && vector == vec, "R11",
        "single pulse and hold", {init_pulse, start_pulse}, 64'h0);
  endtask

  initial begin
    automatic logic [7:0] dests[6] = '{8'h00, 8'h05, 8'h1F, 8'h20, 8'hFF, 8'h81};
    automatic logic [7:0] selfs[4] = '{8'd0, 8'd7, 8'd31, 8'd40};
    automatic int modes[5] = '{0, 1, 4, 5, 6};
    automatic int n = 0;
    repeat (3) @(negedge clk);
    chk(target_mask == '0 && dlv_mode == '0 && vector == '0 && !dispatch_valid
        && init_pulse == '0 && start_pulse == '0 && start_sel == '0 &&
        start_base == '0, "R13", "reset state", 64'(target_mask), 64'h0);
    rst_n = 1'b1;
    for (int sh = 0; sh < 4; sh++)
      for (int lg = 0; lg < 2; lg++)
        foreach (dests[d])
          foreach (selfs[s])
            foreach (modes[m]) begin
              self_id = selfs[s];
              halted = 32'hA5C3_0F69 ^ (32'(n) * 32'h9E37_79B9);
              dispatch(sh, lg, dests[d], modes[m], 8'(n * 13 + 1));
              n++;
            end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule